// File: doc/BRIEF.md
# Edge-Interval Frequency Multiplier Timer

This timer channel measures how many clock cycles pass between rising edges of an external reference pulse, and turns that interval into a faster periodic tick. A 32-bit free-running up counter advances while the channel runs. Each qualified rising edge of the reference input latches that counter into a capture register and raises a capture flag. When the channel runs and reload is not inhibited, the same edge also takes the difference between the new and the previous capture. That interval is shifted right by a programmable power-of-two factor and written into a 16-bit reload register. A down counter restarts from that reload value each time it reaches one. Its one-cycle tick output is therefore the reference frequency multiplied by 1, 2, 4 or 8.

Two compare functions sit beside the capture path. A full-width compare register matches against the free-running counter. An 8-bit compare register is tested against an 8-bit edge counter, but only at the moment a reference edge arrives. All state is reached through a small register port: one write strobe, an address, write data and a combinational read data bus. The block carries no streamed data, so no valid/ready handshake is used. A write takes effect at the clock edge where `reg_wr` is high and is never stalled. Reads never stall either.

Register addresses are as follows. 0 is control: bit 0 run, bit 1 reload inhibit, bits 3:2 shift code. 1 is status: bit 0 capture, bit 1 full-width match, bit 2 edge match. 2 is capture (read-only). 3 is the full-width compare. 4 is the 8-bit compare, in bits 7:0. 5 is reload (read-only). 6 is the free counter (read-only). 7 is a read-only view of the down counter in bits 15:0 and the edge counter in bits 23:16.

Top module: `edge_interval_mult`

## Requirements
- R1: After reset the capture, reload, free counter, control and status registers read 0. The full-width compare reads 0xFFFFFFFF and the 8-bit compare reads 0xFF.
- R2: The free counter rises by exactly one per clock while control bit 0 (run) is 1, and holds its value while run is 0.
- R3: Each rising edge of `ref_in` is passed through a two-stage synchronizer and becomes a single-cycle strobe. The strobe latches the free counter into the capture register and sets status bit 0 at the same clock edge. A falling edge captures nothing.
- R4: On a strobe with run = 1 and control bit 1 (inhibit) = 0, reload becomes (new capture − previous capture) shifted right by the 2-bit code in control bits 3:2 (00→0, 01→1, 10→2, 11→3 places), truncated to 16 bits.
- R5: When inhibit is 1, a strobe leaves the reload register unchanged.
- R6: While run = 1, the down counter decrements each clock. In any cycle where its value is 0 or 1, it loads the reload value at the next edge and `mult_tick` is high for that cycle. With reload N ≥ 1, ticks are exactly N cycles apart.
- R7: Status bit 1 is set when the free counter equals the full-width compare while run = 1.
- R8: An 8-bit edge counter advances on every strobe. Status bit 2 is set only on a strobe that arrives while the edge counter (before it advances) equals the 8-bit compare.
- R9: Writing 1 to a status bit clears it, and writing 0 has no effect. A set and a clear of the same bit in one cycle leave it set.
- R10: Writes to the capture, reload, free counter and counter-view addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ref_in | input | 1 | Asynchronous reference pulse |
| mult_tick | output | 1 | One-cycle multiplied clock tick |

## Verification
On every cycle, the assertions check the following. The strobe never lasts two cycles. The free counter steps or holds according to run. A strobe always leaves the capture flag set, and always advances the edge counter. Reload stays still when no transfer is allowed. Every tick is followed by a load of the reload value. A status write clears a flag unless a set coincides. The arithmetic of the interval and its shift, the 16-bit truncation, and the exact tick spacing for a given reference period can only be shown by the bench scenarios. So can the edge-time comparison of the 8-bit compare, and the set-beats-clear race.

// File: rtl/eim_pkg.sv
package eim_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_CAP  = 3'd2,
    A_CMPA = 3'd3,
    A_CMPB = 3'd4,
    A_RLD  = 3'd5,
    A_FREE = 3'd6,
    A_VIEW = 3'd7
  } reg_addr_e;

  localparam int FLG_CAP   = 0;
  localparam int FLG_CMPA  = 1;
  localparam int FLG_CMPB  = 2;
  localparam int NUM_FLAGS = 3;

  typedef struct packed {
    logic [1:0] mult;
    logic       inhibit;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic strobe_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ref_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign strobe_o = sync_q[STAGES-1] & ~prev_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o); // R3
endmodule

// File: rtl/interval_capture.sv
module interval_capture #(
  parameter int CNT_W = 32,
  parameter int RLD_W = 16,
  parameter int MUL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             inhibit_i,
  input  logic [MUL_W-1:0] mult_i,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] free_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [RLD_W-1:0] rld_o,
  output logic             cmp_hit_o
);
  logic [CNT_W-1:0] free_q, cap_q, span;
  logic [RLD_W-1:0] rld_q, scaled;
  logic             xfer;

  always_comb begin
    span   = free_q - cap_q;
    scaled = RLD_W'(span >> mult_i);
    xfer   = strobe_i && run_i && !inhibit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= '0;
      cap_q  <= '0;
      rld_q  <= '0;
    end else begin
      if (run_i) free_q <= free_q + 1'b1;
      if (strobe_i) cap_q <= free_q;
      if (xfer) rld_q <= scaled;
    end
  end

  assign free_o    = free_q;
  assign cap_o     = cap_q;
  assign rld_o     = rld_q;
  assign cmp_hit_o = run_i && (free_q == cmp_i);

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> free_q == $past(free_q) + 1'b1); // R2
  AST_FREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(free_q)); // R2
  AST_RLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_i || !strobe_i) |=> $stable(rld_q)); // R5
  AST_CAP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> cap_q == $past(free_q)); // R3
endmodule

// File: rtl/reload_down_counter.sv
module reload_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q < W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick_o) cnt_q <= reload_i;
    else if (run_i) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_TICK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_q == $past(reload_i)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/edge_interval_mult.sv
module edge_interval_mult
  import eim_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int RLD_W  = 16,
  parameter int EDGE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ref_in,
  output logic        mult_tick
);
  localparam int PAD_W = CNT_W - EDGE_W - RLD_W;
  localparam int CTL_W = $bits(ctrl_t);

  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   cmpa_q, free_v, cap_v;
  logic [EDGE_W-1:0]  cmpb_q, edge_q;
  logic [RLD_W-1:0]   rld_v, down_v;
  logic               strobe, hit_a, stat_wr;
  logic [NUM_FLAGS-1:0] flags, flag_set;

  ref_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_in), .strobe_o(strobe)
  );

  interval_capture #(.CNT_W(CNT_W), .RLD_W(RLD_W), .MUL_W(2)) u_cap (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl_q.run), .inhibit_i(ctrl_q.inhibit),
    .mult_i(ctrl_q.mult), .strobe_i(strobe), .cmp_i(cmpa_q),
    .free_o(free_v), .cap_o(cap_v), .rld_o(rld_v), .cmp_hit_o(hit_a)
  );

  reload_down_counter #(.W(RLD_W)) u_down (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl_q.run), .reload_i(rld_v),
    .cnt_o(down_v), .tick_o(mult_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmpa_q <= '1;
      cmpb_q <= '1;
      edge_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTL_W-1:0]);
      if (reg_wr && reg_addr == A_CMPA) cmpa_q <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == A_CMPB) cmpb_q <= reg_wdata[EDGE_W-1:0];
      if (strobe) edge_q <= edge_q + 1'b1;
    end
  end

  assign stat_wr = reg_wr && (reg_addr == A_STAT);

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_CAP]  = strobe;
    flag_set[FLG_CMPA] = hit_a;
    flag_set[FLG_CMPB] = strobe && (edge_q == cmpb_q);
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= flag_set[g] | (f_q & ~(stat_wr & reg_wdata[g]));
    end
    assign flags[g] = f_q;

    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && reg_wdata[g] && !flag_set[g]) |=> !f_q); // R9
    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[g] |=> f_q); // R9
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = 32'(ctrl_q);
      A_STAT:  reg_rdata = 32'(flags);
      A_CAP:   reg_rdata = cap_v;
      A_CMPA:  reg_rdata = cmpa_q;
      A_CMPB:  reg_rdata = 32'(cmpb_q);
      A_RLD:   reg_rdata = 32'(rld_v);
      A_FREE:  reg_rdata = free_v;
      default: reg_rdata = {{PAD_W{1'b0}}, edge_q, down_v};
    endcase
  end

  AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> flags[FLG_CAP]); // R3
  AST_EDGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> edge_q == $past(edge_q) + 1'b1); // R8
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(edge_q)); // R8
endmodule

// File: tb/edge_interval_mult_tb.sv
module edge_interval_mult_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ref_in = 1'b0;
  logic        mult_tick;
  int          n_chk = 0;
  int          n_bad = 0;

  localparam logic [2:0] AD_CTRL = 3'd0, AD_STAT = 3'd1, AD_CAP = 3'd2, AD_CMPA = 3'd3,
                         AD_CMPB = 3'd4, AD_RLD = 3'd5, AD_FREE = 3'd6, AD_VIEW = 3'd7;

  always #5 clk = ~clk;

  edge_interval_mult dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ref_in(ref_in), .mult_tick(mult_tick)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic edges(input int n, input int sp);
    int h;
    h = sp / 2;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_in = 1'b1;
      repeat (h - 1) @(negedge clk);
      @(negedge clk); ref_in = 1'b0;
      repeat (sp - h - 1) @(negedge clk);
    end
  endtask

  function automatic logic [31:0] ctl(input bit run, input bit inh, input int sh);
    return {28'd0, 2'(sh), inh, run};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(AD_CAP, d);  chk("R1", "capture", d, 32'h0);
    rd(AD_CMPA, d); chk("R1", "cmpA", d, 32'hFFFF_FFFF);
    rd(AD_CMPB, d); chk("R1", "cmpB", d, 32'hFF);
    rd(AD_RLD, d);  chk("R1", "reload", d, 32'h0);
    rd(AD_STAT, d); chk("R1", "status", d, 32'h0);
    rd(AD_CTRL, d); chk("R1", "ctrl", d, 32'h0);
    rd(AD_FREE, d); chk("R1", "free", d, 32'h0);
  endtask

  task automatic t_free;
    logic [31:0] a, b;
    wr(AD_CTRL, ctl(1, 0, 0));
    rd(AD_FREE, a);
    repeat (10) @(negedge clk);
    rd(AD_FREE, b);
    chk("R2", "free step", b - a, 32'd11);
    wr(AD_CTRL, ctl(0, 0, 0));
    rd(AD_FREE, a);
    repeat (10) @(negedge clk);
    rd(AD_FREE, b);
    chk("R2", "free hold", b - a, 32'd0);
  endtask

  task automatic t_reload(input int sh, input int sp, input logic [31:0] exp, input string req);
    logic [31:0] d;
    wr(AD_CTRL, ctl(1, 0, sh));
    edges(2, sp);
    repeat (5) @(negedge clk);
    rd(AD_RLD, d);
    chk(req, $sformatf("reload shift %0d spacing %0d", sh, sp), d, exp);
  endtask

  task automatic t_capture;
    logic [31:0] a, b, s;
    wr(AD_STAT, 32'h7);
    rd(AD_CAP, a);
    @(negedge clk); ref_in = 1'b1;
    repeat (8) @(negedge clk);
    rd(AD_CAP, b);
    rd(AD_STAT, s);
    chk("R3", "capture flag on rise", s & 32'h1, 32'h1);
    chk("R3", "capture moved on rise", 32'(a != b), 32'h1);
    wr(AD_STAT, 32'h1);
    @(negedge clk); ref_in = 1'b0;
    repeat (8) @(negedge clk);
    rd(AD_CAP, a);
    rd(AD_STAT, s);
    chk("R3", "no capture on fall", a, b);
    chk("R3", "no flag on fall", s & 32'h1, 32'h0);
  endtask

  task automatic t_inhibit;
    logic [31:0] d;
    wr(AD_CTRL, ctl(1, 1, 0));
    edges(2, 150);
    repeat (5) @(negedge clk);
    rd(AD_RLD, d);
    chk("R5", "reload kept under inhibit", d, 32'd25);
    wr(AD_CTRL, ctl(1, 0, 3));
  endtask

  task automatic t_tick(input int n);
    int last, per;
    last = -1; per = -1;
    repeat (3 * n) @(negedge clk);
    for (int k = 0; k < 3 * n + 4; k++) begin
      @(negedge clk);
      #1;
      if (mult_tick) begin
        if (last >= 0 && per < 0) per = k - last;
        last = k;
      end
    end
    chk("R6", "tick period", 32'(per), 32'(n));
  endtask

  task automatic t_cmpa;
    logic [31:0] f, s;
    wr(AD_STAT, 32'h7);
    rd(AD_FREE, f);
    wr(AD_CMPA, f + 32'd500);
    repeat (20) @(negedge clk);
    rd(AD_STAT, s);
    chk("R7", "no early match", s & 32'h2, 32'h0);
    rd(AD_FREE, f);
    wr(AD_CMPA, f + 32'd40);
    repeat (60) @(negedge clk);
    rd(AD_STAT, s);
    chk("R7", "match flag", s & 32'h2, 32'h2);
    wr(AD_STAT, 32'h0);
    rd(AD_STAT, s);
    chk("R9", "write 0 keeps flag", s & 32'h2, 32'h2);
    wr(AD_STAT, 32'h2);
    rd(AD_STAT, s);
    chk("R9", "write 1 clears flag", s & 32'h2, 32'h0);
  endtask

  task automatic t_cmpb;
    logic [31:0] v, s;
    rd(AD_VIEW, v);
    wr(AD_CMPB, 32'((v[23:16] + 8'd2) & 8'hFF));
    wr(AD_STAT, 32'h4);
    edges(2, 20);
    repeat (5) @(negedge clk);
    rd(AD_STAT, s);
    chk("R8", "no edge match before equal", s & 32'h4, 32'h0);
    edges(1, 20);
    repeat (5) @(negedge clk);
    rd(AD_STAT, s);
    chk("R8", "edge match when equal", s & 32'h4, 32'h4);
    rd(AD_VIEW, s);
    chk("R8", "edge counter advanced", 32'(s[23:16]), 32'((v[23:16] + 8'd3) & 8'hFF));
  endtask

  task automatic t_race;
    logic [31:0] s;
    edges(1, 20);
    wr(AD_STAT, 32'h1);
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_addr = AD_STAT; reg_wdata = 32'h1; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(AD_STAT, s);
    chk("R9", "set wins over clear", s & 32'h1, 32'h1);
    @(negedge clk); ref_in = 1'b0;
  endtask

  task automatic t_readonly;
    logic [31:0] a, b;
    wr(AD_CTRL, ctl(0, 0, 0));
    rd(AD_CAP, a);
    wr(AD_CAP, ~a);
    rd(AD_CAP, b);
    chk("R10", "capture not writable", b, a);
    rd(AD_RLD, a);
    wr(AD_RLD, ~a);
    rd(AD_RLD, b);
    chk("R10", "reload not writable", b, a);
    rd(AD_FREE, a);
    wr(AD_FREE, ~a);
    rd(AD_FREE, b);
    chk("R10", "free not writable", b, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_free();
    t_capture();
    t_reload(0, 65600, 32'd64, "R4 truncation");
    t_reload(0, 200, 32'd200, "R4");
    t_reload(1, 200, 32'd100, "R4");
    t_reload(2, 200, 32'd50, "R4");
    t_reload(3, 200, 32'd25, "R4");
    t_inhibit();
    t_tick(25);
    t_cmpa();
    t_cmpb();
    t_race();
    t_readonly();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule